// File: doc/BRIEF.md
# Parallel Port Extended Mode Control Register Bank

This block is the upper register window of an extended-capability parallel port. It keeps the extended control byte, whose top three bits pick how the shared FIFO window behaves. It steers byte writes and reads from the host bus to or from an external 16-entry FIFO. It serves two fixed configuration bytes and returns a status-merged readback of the control byte. It also raises the service interrupt for the FIFO and the DMA transfer engine.

The host bus selects the lower window with `io_hi` = 0 and the upper window with `io_hi` = 1. In the upper window, offset 0 is the FIFO window, offset 1 is the second configuration byte and offset 2 is the control byte. In the lower window, only offset 0, the data byte, concerns this block. The FIFO and the transfer engine sit outside the block. The FIFO reports full, empty and threshold status and shows its head entry first-word-fall-through. The block sends push and pop strobes to it, and one-cycle pulses to clear it, start a DMA fetch or stop the engine.

The mode field values used below are 000 (standard), 010 (FIFO output), 011 (extended transfer), 110 (FIFO test) and 111 (configuration). "Direction" is bit 5 of the port's control register, supplied on `ctl_dir`: 0 is forward and 1 is reverse.

Top module: `ecp_ecr_unit`

## Requirements
- R1: After reset, the control byte holds 0x15, and `irq` and `autofeed` are 0. With the FIFO empty and not full, a control-byte read returns 0x15.
- R2: A control-byte read (upper window, offset 2) returns the stored byte ORed with the service status in bit 2, FIFO full in bit 1 and FIFO empty in bit 0.
- R3: A FIFO-window write pushes the byte with tag 1 in mode 010, in mode 110, and in mode 011 only while `ctl_dir` = 0. It pushes nothing in any other mode, and it never pushes while `fifo_full` = 1. `fifo_push` is a strobe in the same cycle as the write.
- R4: A write to the lower-window data byte in mode 011 pushes the byte with tag 0 (a command entry). In every other mode it pushes nothing.
- R5: A FIFO-window read pops the head entry and returns it in mode 110, and in mode 011 only while `ctl_dir` = 1. An empty FIFO, or any other mode except 111, returns 0xFF without a pop. Read data appears on `io_rdata` one cycle after the read.
- R6: In mode 111, a FIFO-window read returns the constant 0x14 and does not pop.
- R7: In mode 111, offset 1 reads 0x08 ORed with bits 5:4 = 11 when `irq_num` = 5, the DMA channel in bits 2:0 when `dma_chan` is 1 to 3, and `irq` in bit 6. In any other mode it reads 0xFF.
- R8: A control write that takes bit 2 from 1 to 0 pulses `fifo_clear` and clears the DMA done status. If bit 3 is also written as 1, it pulses `dma_start` and clears the FIFO service status.
- R9: While the stored bit 3 is 0, the FIFO service status tracks the FIFO every cycle. In reverse (`ctl_dir` = 1) it equals `fifo_thresh`; in forward it equals the inverse of `fifo_thresh`.
- R10: `xfer_done` while bit 3 = 1 and bit 2 = 0 sets the DMA done status. The status stays set until the next write that takes bit 2 from 1 to 0.
- R11: `irq` equals (NOT stored bit 2) AND (FIFO service status OR DMA done status), registered one cycle after that state.
- R12: On every control write, `autofeed` becomes 1 if bit 3 or bit 2 of the written value is 1, and 0 if both are 0.
- R13: A control write that takes bit 2 from 0 to 1 pulses `engine_stop` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Bus write strobe |
| io_rd | input | 1 | Bus read strobe |
| io_hi | input | 1 | 1 selects the upper window, 0 the lower |
| io_off | input | 2 | Offset inside the window |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| ctl_dir | input | 1 | Port direction (control bit 5): 1 is reverse |
| irq_num | input | 4 | Interrupt line number of the port |
| dma_chan | input | 3 | DMA channel number of the port |
| fifo_full | input | 1 | FIFO full |
| fifo_empty | input | 1 | FIFO empty |
| fifo_thresh | input | 1 | FIFO at or past its threshold of 8 |
| fifo_head | input | 8 | Head entry of the FIFO |
| xfer_done | input | 1 | Transfer engine finished its DMA reads |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_push_tag | output | 1 | Tag of the pushed entry: 1 data, 0 command |
| fifo_push_data | output | 8 | Byte to push |
| fifo_pop | output | 1 | Pop strobe to the FIFO |
| fifo_clear | output | 1 | One-cycle FIFO reset pulse |
| dma_start | output | 1 | One-cycle DMA fetch start pulse |
| engine_stop | output | 1 | One-cycle engine stop pulse |
| autofeed | output | 1 | Autofeed line level |
| irq | output | 1 | Service interrupt |

## Verification
The hardest state to reach is the DMA done interrupt. It needs bit 3 set and bit 2 set first, then a second control write that clears bit 2, and only after that an `xfer_done` pulse. The stimulus walks that order, then checks that the interrupt falls when bit 2 is set again and that the readback status clears on the next falling write. The interrupt-pending bit of the second configuration byte can only be seen from mode 111. So the bench enters mode 111 with bit 2 cleared, which lets the FIFO service status raise `irq` while that register is readable.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STD    = 3'b000,
    MD_BIDIR  = 3'b001,
    MD_FIFO   = 3'b010,
    MD_XFER   = 3'b011,
    MD_RSV4   = 3'b100,
    MD_RSV5   = 3'b101,
    MD_TEST   = 3'b110,
    MD_CFG    = 3'b111
  } ecp_mode_e;

  localparam logic [1:0] OFF_FIFO = 2'd0;
  localparam logic [1:0] OFF_CFGB = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;

  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h15;
  localparam logic [BYTE_W-1:0] CFGA_VAL  = 8'h14;
  localparam logic [BYTE_W-1:0] CFGB_BASE = 8'h08;
  localparam logic [BYTE_W-1:0] IDLE_RD   = 8'hFF;
endpackage

// File: rtl/ecp_ctrl_reg.sv
module ecp_ctrl_reg
  import ecp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          io_hi,
  input  logic [AW-1:0] io_off,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] ctrl_q,
  output logic          svc_fall,
  output logic          dma_go,
  output logic          dmaen_next,
  output logic          autofeed,
  output logic          fifo_clear,
  output logic          dma_start,
  output logic          engine_stop
);
  logic ctrl_wr, svc_rise;

  assign ctrl_wr    = io_wr && io_hi && (io_off == AW'(OFF_CTRL));
  assign svc_fall   = ctrl_wr && ctrl_q[2] && !io_wdata[2];
  assign svc_rise   = ctrl_wr && !ctrl_q[2] && io_wdata[2];
  assign dma_go     = svc_fall && io_wdata[3];
  assign dmaen_next = ctrl_wr ? io_wdata[3] : ctrl_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= DW'(CTRL_RST);
      autofeed    <= 1'b0;
      fifo_clear  <= 1'b0;
      dma_start   <= 1'b0;
      engine_stop <= 1'b0;
    end else begin
      fifo_clear  <= svc_fall;
      dma_start   <= dma_go;
      engine_stop <= svc_rise;
      if (ctrl_wr) begin
        ctrl_q   <= io_wdata;
        autofeed <= |io_wdata[3:2];
      end
    end
  end

  // R8: a clear pulse follows a stored bit 2 falling
  p_clear_fall_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |-> (!ctrl_q[2] && $past(ctrl_q[2])));
  // R8: a DMA start comes only with a clear and DMA enabled
  p_start_dma_r8: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> (fifo_clear && ctrl_q[3]));
  // R13: a stop pulse follows a stored bit 2 rising
  p_stop_rise_r13: assert property (@(posedge clk) disable iff (rst)
    engine_stop |-> (ctrl_q[2] && !$past(ctrl_q[2])));
endmodule

// File: rtl/ecp_service.sv
module ecp_service (
  input  logic clk,
  input  logic rst,
  input  logic svc_off,
  input  logic dma_en,
  input  logic svc_fall,
  input  logic dma_go,
  input  logic dmaen_next,
  input  logic ctl_dir,
  input  logic fifo_thresh,
  input  logic xfer_done,
  output logic svc_stat,
  output logic irq
);
  logic fifo_stat_q, dma_stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_stat_q <= 1'b0;
      dma_stat_q  <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (dma_go)
        fifo_stat_q <= 1'b0;
      else if (!dmaen_next)
        fifo_stat_q <= ctl_dir ? fifo_thresh : !fifo_thresh;

      if (svc_fall)
        dma_stat_q <= 1'b0;
      else if (xfer_done && dma_en && !svc_off)
        dma_stat_q <= 1'b1;

      irq <= !svc_off && (fifo_stat_q || dma_stat_q);
    end
  end

  assign svc_stat = fifo_stat_q || dma_stat_q;

  // R11: service interrupt masked while bit 2 is set
  p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
    svc_off |=> !irq);
  // R10: engine completion raises the service status
  p_dma_done_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && dma_en && !svc_off) |=> svc_stat);
endmodule

// File: rtl/ecp_port_route.sv
module ecp_port_route
  import ecp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 2,
  parameter int IRQ_W     = 4,
  parameter int DMA_W     = 3,
  parameter int IRQ_MATCH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             io_hi,
  input  logic [AW-1:0]    io_off,
  input  logic [DW-1:0]    io_wdata,
  input  logic [DW-1:0]    ctrl_q,
  input  logic             svc_stat,
  input  logic             irq,
  input  logic             ctl_dir,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic [DMA_W-1:0] dma_chan,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_head,
  output logic             fifo_push,
  output logic             fifo_push_tag,
  output logic [DW-1:0]    fifo_push_data,
  output logic             fifo_pop,
  output logic [DW-1:0]    io_rdata
);
  ecp_mode_e mode;
  logic          push_c, tag_c, pop_c;
  logic [DW-1:0] rd_c, cfgb;

  assign mode = ecp_mode_e'(ctrl_q[DW-1 -: 3]);

  always_comb begin
    cfgb = DW'(CFGB_BASE);
    if (irq) cfgb[6] = 1'b1;
    if (irq_num == IRQ_W'(IRQ_MATCH)) cfgb[5:4] = 2'b11;
    if (dma_chan >= DMA_W'(1) && dma_chan <= DMA_W'(3)) cfgb = cfgb | DW'(dma_chan);
  end

  always_comb begin
    push_c = 1'b0;
    tag_c  = 1'b1;
    if (io_wr && io_hi && io_off == AW'(OFF_FIFO)) begin
      unique case (mode)
        MD_FIFO, MD_TEST: push_c = 1'b1;
        MD_XFER:          push_c = !ctl_dir;
        default:          push_c = 1'b0;
      endcase
    end else if (io_wr && !io_hi && io_off == AW'(0) && mode == MD_XFER) begin
      push_c = 1'b1;
      tag_c  = 1'b0;
    end
  end

  always_comb begin
    rd_c  = DW'(IDLE_RD);
    pop_c = 1'b0;
    if (io_hi) begin
      if (io_off == AW'(OFF_FIFO)) begin
        unique case (mode)
          MD_XFER: if (ctl_dir && !fifo_empty) begin pop_c = 1'b1; rd_c = fifo_head; end
          MD_TEST: if (!fifo_empty) begin pop_c = 1'b1; rd_c = fifo_head; end
          MD_CFG:  rd_c = DW'(CFGA_VAL);
          default: rd_c = DW'(IDLE_RD);
        endcase
      end else if (io_off == AW'(OFF_CFGB)) begin
        if (mode == MD_CFG) rd_c = cfgb;
      end else if (io_off == AW'(OFF_CTRL)) begin
        rd_c = ctrl_q | {{(DW-3){1'b0}}, svc_stat, fifo_full, fifo_empty};
      end
    end
  end

  assign fifo_push      = push_c && !fifo_full;
  assign fifo_push_tag  = tag_c;
  assign fifo_push_data = io_wdata;
  assign fifo_pop       = io_rd && pop_c;

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= DW'(IDLE_RD);
    else if (io_rd) io_rdata <= rd_c;
  end

  // R3: no push into a full FIFO
  p_push_room_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);
  // R3: data pushes in transfer mode only when forward
  p_xfer_dir_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && fifo_push_tag && ctrl_q[7:5] == 3'b011) |-> !ctl_dir);
  // R5: no pop from an empty FIFO
  p_pop_data_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);
endmodule

// File: rtl/ecp_ecr_unit.sv
module ecp_ecr_unit
  import ecp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 2,
  parameter int IRQ_W     = 4,
  parameter int DMA_W     = 3,
  parameter int IRQ_MATCH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             io_hi,
  input  logic [AW-1:0]    io_off,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic             ctl_dir,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic [DMA_W-1:0] dma_chan,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             fifo_thresh,
  input  logic [DW-1:0]    fifo_head,
  input  logic             xfer_done,
  output logic             fifo_push,
  output logic             fifo_push_tag,
  output logic [DW-1:0]    fifo_push_data,
  output logic             fifo_pop,
  output logic             fifo_clear,
  output logic             dma_start,
  output logic             engine_stop,
  output logic             autofeed,
  output logic             irq
);
  logic [DW-1:0] ctrl_q;
  logic          svc_fall, dma_go, dmaen_next, svc_stat;

  ecp_ctrl_reg #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_hi(io_hi), .io_off(io_off),
    .io_wdata(io_wdata), .ctrl_q(ctrl_q), .svc_fall(svc_fall), .dma_go(dma_go),
    .dmaen_next(dmaen_next), .autofeed(autofeed), .fifo_clear(fifo_clear),
    .dma_start(dma_start), .engine_stop(engine_stop)
  );

  ecp_service u_svc (
    .clk(clk), .rst(rst), .svc_off(ctrl_q[2]), .dma_en(ctrl_q[3]),
    .svc_fall(svc_fall), .dma_go(dma_go), .dmaen_next(dmaen_next),
    .ctl_dir(ctl_dir), .fifo_thresh(fifo_thresh), .xfer_done(xfer_done),
    .svc_stat(svc_stat), .irq(irq)
  );

  ecp_port_route #(.DW(DW), .AW(AW), .IRQ_W(IRQ_W), .DMA_W(DMA_W),
                   .IRQ_MATCH(IRQ_MATCH)) u_route (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_hi(io_hi),
    .io_off(io_off), .io_wdata(io_wdata), .ctrl_q(ctrl_q), .svc_stat(svc_stat),
    .irq(irq), .ctl_dir(ctl_dir), .irq_num(irq_num), .dma_chan(dma_chan),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
    .fifo_push(fifo_push), .fifo_push_tag(fifo_push_tag),
    .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop), .io_rdata(io_rdata)
  );
endmodule

// File: tb/ecp_ecr_unit_tb.sv
module ecp_ecr_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 0, io_rd = 0, io_hi = 0;
  logic [1:0] io_off = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic       ctl_dir = 0;
  logic [3:0] irq_num = 4'd7;
  logic [2:0] dma_chan = 3'd0;
  logic       fifo_full = 0, fifo_empty = 1, fifo_thresh = 0;
  logic [7:0] fifo_head = 8'h00;
  logic       xfer_done = 0;
  logic       fifo_push, fifo_push_tag, fifo_pop;
  logic [7:0] fifo_push_data;
  logic       fifo_clear, dma_start, engine_stop, autofeed, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_dly = 0;
  logic [7:0] exp_q[$];
  string      lab_q[$];

  always #5 clk = ~clk;

  ecp_ecr_unit u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_hi(io_hi),
    .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ctl_dir(ctl_dir), .irq_num(irq_num), .dma_chan(dma_chan),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_thresh(fifo_thresh),
    .fifo_head(fifo_head), .xfer_done(xfer_done), .fifo_push(fifo_push),
    .fifo_push_tag(fifo_push_tag), .fifo_push_data(fifo_push_data),
    .fifo_pop(fifo_pop), .fifo_clear(fifo_clear), .dma_start(dma_start),
    .engine_stop(engine_stop), .autofeed(autofeed), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string lbl);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", lbl, act, exp);
    end
  endtask

  // scoreboard monitor: compares registered read data one cycle after the read
  always @(posedge clk) rd_dly <= io_rd;
  always @(negedge clk) begin
    if (rd_dly) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL read without expectation: actual %h expected none", io_rdata);
      end else begin
        logic [7:0] e;
        string l;
        e = exp_q.pop_front();
        l = lab_q.pop_front();
        chk(io_rdata, e, l);
      end
    end
  end

  task automatic wr(input logic hi, input logic [1:0] off, input logic [7:0] d,
                    input logic exp_push, input logic exp_tag, input string lbl);
    @(negedge clk);
    io_wr = 1; io_hi = hi; io_off = off; io_wdata = d;
    #1;
    chk({7'b0, fifo_push}, {7'b0, exp_push}, {lbl, " push"});
    if (exp_push) begin
      chk({7'b0, fifo_push_tag}, {7'b0, exp_tag}, {lbl, " tag"});
      chk(fifo_push_data, d, {lbl, " data"});
    end
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic hi, input logic [1:0] off, input logic [7:0] exp,
                    input logic exp_pop, input string lbl);
    exp_q.push_back(exp);
    lab_q.push_back(lbl);
    @(negedge clk);
    io_rd = 1; io_hi = hi; io_off = off;
    #1;
    chk({7'b0, fifo_pop}, {7'b0, exp_pop}, {lbl, " pop"});
    @(negedge clk);
    io_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk({7'b0, irq}, 8'h00, "R1 irq after reset");
    chk({7'b0, autofeed}, 8'h00, "R1 autofeed after reset");
    rd(1, 2'd2, 8'h15, 0, "R1 ctrl readback after reset");
    // R3/R4 standard mode pushes nothing
    wr(1, 2'd0, 8'h11, 0, 1, "R3 mode 000 fifo write");
    wr(0, 2'd0, 8'h12, 0, 0, "R4 mode 000 data write");

    // enter mode 010 with bit 2 cleared
    wr(1, 2'd2, 8'h40, 0, 1, "R8 ctrl write 0x40");
    chk({7'b0, fifo_clear}, 8'h01, "R8 clear pulse on falling bit2");
    chk({7'b0, dma_start}, 8'h00, "R8 no dma start without bit3");
    chk({7'b0, autofeed}, 8'h00, "R12 autofeed low for bits 3:2 = 00");
    idle(1);
    chk({7'b0, irq}, 8'h01, "R11 irq from fifo service status");
    chk({7'b0, fifo_clear}, 8'h00, "R8 clear is one cycle");
    rd(1, 2'd2, 8'h45, 0, "R2 ctrl readback empty");
    fifo_full = 1; fifo_empty = 0;
    rd(1, 2'd2, 8'h46, 0, "R2 ctrl readback full");
    wr(1, 2'd0, 8'h21, 0, 1, "R3 no push while full");
    fifo_full = 0; fifo_empty = 1;
    wr(1, 2'd0, 8'h22, 1, 1, "R3 mode 010 push");
    wr(0, 2'd0, 8'h23, 0, 0, "R4 mode 010 data write ignored");

    // R9 threshold tracking
    fifo_thresh = 1;
    idle(3);
    chk({7'b0, irq}, 8'h00, "R9 forward at threshold no service");
    rd(1, 2'd2, 8'h41, 0, "R9 readback bit2 clear");
    ctl_dir = 1;
    idle(3);
    chk({7'b0, irq}, 8'h01, "R9 reverse at threshold service");
    ctl_dir = 0; fifo_thresh = 0;

    // mode 011, bit 2 set
    wr(1, 2'd2, 8'h64, 0, 1, "R13 ctrl write 0x64");
    chk({7'b0, engine_stop}, 8'h01, "R13 stop pulse on rising bit2");
    chk({7'b0, autofeed}, 8'h01, "R12 autofeed high for bit2");
    idle(1);
    chk({7'b0, irq}, 8'h00, "R11 irq masked by bit2");
    chk({7'b0, engine_stop}, 8'h00, "R13 stop is one cycle");
    wr(0, 2'd0, 8'h31, 1, 0, "R4 mode 011 data write command tag");
    wr(1, 2'd0, 8'h32, 1, 1, "R3 mode 011 forward push");
    ctl_dir = 1;
    wr(1, 2'd0, 8'h33, 0, 1, "R3 mode 011 reverse no push");
    fifo_empty = 0; fifo_head = 8'h3C;
    rd(1, 2'd0, 8'h3C, 1, "R5 mode 011 reverse pop");
    fifo_empty = 1;
    rd(1, 2'd0, 8'hFF, 0, "R5 mode 011 empty read");
    ctl_dir = 0; fifo_empty = 0;
    rd(1, 2'd0, 8'hFF, 0, "R5 mode 011 forward read no pop");
    fifo_empty = 1;
    rd(1, 2'd1, 8'hFF, 0, "R7 cfg B outside mode 111");

    // mode 110 test
    wr(1, 2'd2, 8'hC4, 0, 1, "R3 ctrl write 0xC4");
    wr(1, 2'd0, 8'h44, 1, 1, "R3 mode 110 push");
    fifo_empty = 0; fifo_head = 8'h5A;
    rd(1, 2'd0, 8'h5A, 1, "R5 mode 110 pop");
    fifo_full = 1;
    wr(1, 2'd0, 8'h45, 0, 1, "R3 mode 110 full no push");
    fifo_full = 0; fifo_empty = 1;
    rd(1, 2'd0, 8'hFF, 0, "R5 mode 110 empty read");

    // mode 111 configuration
    wr(1, 2'd2, 8'hE4, 0, 1, "R6 ctrl write 0xE4");
    fifo_empty = 0;
    rd(1, 2'd0, 8'h14, 0, "R6 cfg A constant no pop");
    fifo_empty = 1;
    irq_num = 4'd5; dma_chan = 3'd2;
    rd(1, 2'd1, 8'h3A, 0, "R7 cfg B line 5 channel 2");
    wr(1, 2'd0, 8'h46, 0, 1, "R3 mode 111 no push");
    wr(1, 2'd2, 8'hE0, 0, 1, "R7 ctrl write 0xE0");
    idle(1);
    irq_num = 4'd7; dma_chan = 3'd0;
    rd(1, 2'd1, 8'h48, 0, "R7 cfg B irq pending");
    dma_chan = 3'd4;
    rd(1, 2'd1, 8'h48, 0, "R7 cfg B channel 4 ignored");
    irq_num = 4'd5; dma_chan = 3'd3;
    rd(1, 2'd1, 8'h7B, 0, "R7 cfg B all fields");
    irq_num = 4'd7; dma_chan = 3'd0;

    // DMA path
    wr(1, 2'd2, 8'h4C, 0, 1, "R13 ctrl write 0x4C");
    chk({7'b0, engine_stop}, 8'h01, "R13 stop pulse again");
    chk({7'b0, autofeed}, 8'h01, "R12 autofeed high for bits 3:2 = 11");
    wr(1, 2'd2, 8'h48, 0, 1, "R8 ctrl write 0x48");
    chk({7'b0, dma_start}, 8'h01, "R8 dma start pulse");
    chk({7'b0, fifo_clear}, 8'h01, "R8 clear with dma start");
    idle(2);
    chk({7'b0, irq}, 8'h00, "R8 statuses cleared no irq");
    rd(1, 2'd2, 8'h49, 0, "R8 readback status cleared");
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R10 irq on transfer done");
    rd(1, 2'd2, 8'h4D, 0, "R10 readback done status");
    wr(1, 2'd2, 8'h4C, 0, 1, "R11 ctrl write 0x4C masks");
    idle(1);
    chk({7'b0, irq}, 8'h00, "R11 irq falls with bit2 set");
    rd(1, 2'd2, 8'h4D, 0, "R10 done status held");
    wr(1, 2'd2, 8'h48, 0, 1, "R8 ctrl write 0x48 again");
    rd(1, 2'd2, 8'h49, 0, "R8 done status cleared by fall");
    wr(1, 2'd2, 8'h00, 0, 1, "R12 ctrl write 0x00");
    chk({7'b0, autofeed}, 8'h00, "R12 autofeed low again");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule